// File: doc/BRIEF.md
# Multi-Channel Interrupt Status Collector

This block gathers interrupt requests from up to four CAN controller channels onto one shared host interrupt line. Each channel drives a level request; a rising edge on that level latches a flag in a status half-word. A separate enable half-word selects which latched flags may drive the shared line. The line itself is the registered OR of the enabled flags in the low byte.

The host reaches both halves through a small register port. The status half is read directly and acknowledged by writing ones: each one clears the matching flag, and each zero leaves its flag alone. The enable half is stored and read back as written. Host software normally acknowledges a channel by writing back that channel's own mask. It enables a channel by OR-ing the mask into the current enable value, and it silences every channel at once by writing zero.

Channels are not mapped to status bits in order. The bit position of each channel is fixed because host software decodes it.

Top module: `irq_collector`

## Requirements
- R1: After a synchronous active-low reset, the status half reads 0x0000, the enable half reads 0x0000 and `irq` is 0.
- R2: A channel's flag is set on the clock edge where its request is first sampled high after being low. The flag positions are: channel 0 at bit 1 (0x0002), channel 1 at bit 0 (0x0001), channel 2 at bit 6 (0x0040), and channel 3 at bit 7 (0x0080).
- R3: A request held high sets its flag only once. After the flag is cleared, it stays clear while the request remains high.
- R4: A write to the status half (`bus_half`=0) clears every flag whose bit is 1 in `bus_wdata`. Flags at bits written 0 keep their value.
- R5: When a new rising request and a clear of the same flag fall in the same cycle, the flag ends up set.
- R6: A write to the enable half (`bus_half`=1) stores all 16 bits of `bus_wdata`. They read back unchanged on the next cycle.
- R7: `irq` is 1 on the cycle after any bit of the low byte has both its status and its enable set.
- R8: A status flag whose enable bit is clear never asserts `irq`.
- R9: Writing 0x0000 to the enable half drops `irq` one cycle after the write edge. The latched status is kept.
- R10: Status bits that no channel maps to always read 0, and writes to them have no effect.
- R11: `irq` deasserts one cycle after the edge that clears the last enabled flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_req | input | 4 | Level interrupt request from each channel |
| bus_wr | input | 1 | Register write strobe |
| bus_half | input | 1 | Half select: 0 = status, 1 = enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected half (combinational) |
| irq | output | 1 | Shared host interrupt line |

## Verification
The assertions assume that channel requests and bus writes are synchronous to `clk` and stable around its rising edge. They also assume that a write strobe lasts exactly one cycle per access. The bench drives every input on the falling edge, holds `bus_wr` for a single cycle, and samples outputs on the falling edge. This keeps every edge-detect and write-one-to-clear event cleanly inside one clock. The bench sweeps all sixteen request patterns and all 256 low-byte enable values against a fully latched status.

// File: rtl/irq_collector_pkg.sv
// Package: shared widths and the fixed channel-to-status-bit map.
// Assumes at most four channels; the map is decoded by host software.
package irq_collector_pkg;
    localparam int MAX_CHAN = 4;
    localparam int HALF_W   = 16;
    localparam int LINE_W   = 8;

    // Returns the status/enable bit position owned by a channel.
    function automatic int chan_bit(input int ch);
        case (ch)
            0:       return 1;
            1:       return 0;
            2:       return 6;
            default: return 7;
        endcase
    endfunction
endpackage

// File: rtl/irq_flag_cell.sv
// Module: one channel's edge-detected, write-one-to-clear status flag.
// Assumes req is synchronous to clk. A new edge wins over a clear.
module irq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic clr,
    output logic flag
);
    logic req_q;
    logic rise;

    assign rise = req & ~req_q;

    // Remember the previous request level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req;
    end

    // Set on a rising request, clear on acknowledge; set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (rise) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

    assert_set_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !req_q) |=> flag);
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !req_q && clr) |=> flag);
    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(req && !req_q)) |=> !flag);
    assert_level_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && req_q && !clr) |=> !flag);
endmodule

// File: rtl/irq_enable_reg.sv
// Module: enable half-word storage, written whole by the host.
// Assumes a single-cycle write strobe.
module irq_enable_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Load the full enable word on a write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (wr) q <= wdata;
    end

    assert_enable_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (q == $past(wdata)));
endmodule

// File: rtl/irq_line_reduce.sv
// Module: registered OR of enabled status bits onto the shared line.
// Assumes status and enable are already aligned bit for bit.
module irq_line_reduce #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status,
    input  logic [W-1:0] enable,
    output logic         irq
);
    // Register the reduction so the shared line is glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(status & enable);
    end
endmodule

// File: rtl/irq_collector.sv
// Module: top of the interrupt collector. It builds the status half from
// per-channel flags at their fixed bit positions, stores the enables, and
// drives one shared line.
// Assumes NUM_CHAN is between 1 and 4; absent channels stay zero.
module irq_collector
    import irq_collector_pkg::*;
#(
    parameter int NUM_CHAN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAX_CHAN-1:0] chan_req,
    input  logic              bus_wr,
    input  logic              bus_half,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              irq
);
    logic [MAX_CHAN-1:0] flag;
    logic [MAX_CHAN-1:0] clr;
    logic [HALF_W-1:0]   status;
    logic [HALF_W-1:0]   enable;
    logic                stat_wr;
    logic                en_wr;

    assign stat_wr = bus_wr & ~bus_half;
    assign en_wr   = bus_wr &  bus_half;

    // Route the acknowledge bit of each channel from its own position.
    always_comb begin
        for (int ch = 0; ch < MAX_CHAN; ch++)
            clr[ch] = stat_wr & bus_wdata[chan_bit(ch)];
    end

    // One flag cell per present channel; absent channels are tied low.
    generate
        for (genvar g = 0; g < MAX_CHAN; g++) begin : g_chan
            if (g < NUM_CHAN) begin : g_on
                irq_flag_cell u_cell (
                    .clk  (clk),
                    .rst_n(rst_n),
                    .req  (chan_req[g]),
                    .clr  (clr[g]),
                    .flag (flag[g])
                );
            end else begin : g_off
                assign flag[g] = 1'b0;
            end
        end
    endgenerate

    // Scatter the channel flags into their status positions.
    always_comb begin
        status = '0;
        for (int ch = 0; ch < MAX_CHAN; ch++)
            status[chan_bit(ch)] = flag[ch];
    end

    irq_enable_reg #(.W(HALF_W)) u_en (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (en_wr),
        .wdata(bus_wdata),
        .q    (enable)
    );

    irq_line_reduce #(.W(LINE_W)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .status(status[LINE_W-1:0]),
        .enable(enable[LINE_W-1:0]),
        .irq   (irq)
    );

    // Present the selected half to the host.
    assign bus_rdata = bus_half ? enable : status;

    assert_irq_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status[LINE_W-1:0] & enable[LINE_W-1:0])) |=> irq);
    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status[LINE_W-1:0] & enable[LINE_W-1:0])) |=> !irq);
    assert_en_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && bus_wdata == '0) |=> ##1 !irq);
endmodule

// File: tb/sim_irq_collector.sv
module sim_irq_collector;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  chan_req = '0;
    logic        bus_wr = 1'b0;
    logic        bus_half = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_collector u0 (
        .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .bus_wr(bus_wr),
        .bus_half(bus_half), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    // Expected status from a request pattern, using the stated bit map.
    function automatic logic [15:0] map_req(input logic [3:0] p);
        logic [15:0] m = '0;
        if (p[0]) m[1] = 1'b1;
        if (p[1]) m[0] = 1'b1;
        if (p[2]) m[6] = 1'b1;
        if (p[3]) m[7] = 1'b1;
        return m;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic rd(input logic half, output logic [15:0] v);
        bus_half = half;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic half, input logic [15:0] d);
        bus_half = half; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) step();
        rst_n = 1'b1;
        rd(1'b0, v); check("R1 status", v, 16'h0000);
        rd(1'b1, v); check("R1 enable", v, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'h0000);

        // R2, R10, R4, R8: every request pattern, enables all clear
        for (int p = 0; p < 16; p++) begin
            chan_req = 4'(p); step();
            rd(1'b0, v); check("R2 map", v, map_req(4'(p)));
            check("R8 masked", {15'd0, irq}, 16'h0000);
            chan_req = '0; step();
            wr(1'b0, 16'hFFFF);
            rd(1'b0, v); check("R4/R10 clear all", v, 16'h0000);
        end

        // R10: writing ones to unmapped bits sets nothing
        wr(1'b0, 16'hFF3C);
        rd(1'b0, v); check("R10 unmapped", v, 16'h0000);

        // R3: held request does not re-set after clear
        chan_req = 4'b0001; step();
        rd(1'b0, v); check("R3 first set", v, 16'h0002);
        wr(1'b0, 16'h0002); step(); step();
        rd(1'b0, v); check("R3 held level", v, 16'h0000);
        chan_req = '0; step();

        // R4: selective clear
        chan_req = 4'hF; step(); chan_req = '0; step();
        rd(1'b0, v); check("R4 all set", v, 16'h00C3);
        wr(1'b0, 16'h0002);
        rd(1'b0, v); check("R4 clear ch0", v, 16'h00C1);
        wr(1'b0, 16'h0040);
        rd(1'b0, v); check("R4 clear ch2", v, 16'h0081);
        wr(1'b0, 16'hFFFF);

        // R5: set beats clear in the same cycle
        chan_req = 4'b0100;
        wr(1'b0, 16'h0040);
        rd(1'b0, v); check("R5 set wins", v, 16'h0040);
        chan_req = '0; step();
        wr(1'b0, 16'hFFFF);

        // R6: enable readback
        wr(1'b1, 16'hA5C3);
        rd(1'b1, v); check("R6 readback", v, 16'hA5C3);
        wr(1'b1, 16'h5A3C);
        rd(1'b1, v); check("R6 readback2", v, 16'h5A3C);

        // R7/R8: enable sweep with all flags latched
        chan_req = 4'hF; step(); chan_req = '0; step();
        for (int e = 0; e < 256; e++) begin
            wr(1'b1, 16'(e)); step();
            check(((e & 8'hC3) != 0) ? "R7 enabled" : "R8 masked",
                  {15'd0, irq}, {15'd0, ((e & 8'hC3) != 0)});
        end

        // R9: zero enable drops irq one cycle after the write edge, status kept
        wr(1'b1, 16'h00C3); step();
        check("R9 irq before", {15'd0, irq}, 16'h0001);
        wr(1'b1, 16'h0000);
        check("R9 irq at write edge", {15'd0, irq}, 16'h0001);
        step();
        check("R9 irq dropped", {15'd0, irq}, 16'h0000);
        rd(1'b0, v); check("R9 status kept", v, 16'h00C3);

        // R11: clear the last enabled flag
        wr(1'b0, 16'h00C1);
        wr(1'b1, 16'h0002); step();
        check("R11 irq high", {15'd0, irq}, 16'h0001);
        wr(1'b0, 16'h0002);
        check("R11 irq still high", {15'd0, irq}, 16'h0001);
        step();
        check("R11 irq low", {15'd0, irq}, 16'h0000);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule